// File: doc/BRIEF.md
# Low-Power Compare Timer

A wake-capable timer for an always-on region. A slow timer clock, presented to the block as a one-cycle enable pulse `tick` on the fast bus clock, drives a prescaler. The prescaler in turn advances an up-counter. When the counter reaches the compare value, the block raises an interrupt flag. If wakeup is enabled, it also raises a separate wakeup flag. Software clears each flag on its own.

Software sets up the timer through a small write port. Address 0 is control, address 1 is the compare value, and address 2 is the flag-clear word. Control and compare writes are staged and land only after three slow ticks, which models the latency of the slow domain. Flag clears act on the next bus edge.

In continuous mode the counter keeps running through a match. In periodic mode it restarts from zero on each match. Changing the compare value never disturbs the running count, but a stop followed by a start clears it.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset the count is 0, both flags and `irq_o` are 0, the timer is stopped (ticks do not advance the count), the prescale is 0 and the compare value is all ones.
- R2: A write to address 0 (control) or address 1 (compare, bits [CNT_W-1:0]) takes effect at the third `tick` after the write. Before that tick, the old setting still governs.
- R3: While running, the count advances by one on every (P+1)-th tick, where P is control bits [14:8]. Without a tick the count does not change.
- R4: With control bit 3 = 0 (continuous), a match leaves the counter at the compare value and counting carries on past it.
- R5: With control bit 3 = 1 (periodic), the advance that would reach the compare value returns the count to 0 instead. The period is therefore the compare value in advances.
- R6: A compare value of 0 or 1 behaves as 2.
- R7: Writing a new compare value while running leaves the current count unchanged.
- R8: Clearing control bit 0 (run) holds the count. Setting it again, once applied, clears the count to 0.
- R9: A match sets the interrupt flag. It sets the wakeup flag only when control bit 2 (wake enable) is 1.
- R10: A write to address 2 clears the interrupt flag where data bit 0 is 1 and the wakeup flag where data bit 1 is 1. Each clear is independent and lands on the next clock edge.
- R11: A match in the same cycle as a clear of the same flag leaves that flag set.
- R12: `irq_o` is the interrupt flag gated by control bit 1 (interrupt enable). Masking it stops neither the counter nor the flag.
- R13: The counter wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per slow timer-clock cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare, 2 flag clear |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | 1 | Masked interrupt request |
| irq_flag_o | output | 1 | Raw interrupt flag |
| wake_flag_o | output | 1 | Wakeup flag |

## Verification
The bench counts ticks to confirm that a control or compare write lands on exactly the third tick. A design that applied it a tick early or late would show a count that is off by one at the probe points. It drives compare values of 0 and 4 and then a large one, in both modes, and checks both the landing point of the count and the flag. A design that did not apply the floor of 2, or that reset the counter on a continuous-mode match, would give a wrong count or a missing flag. A match is forced into the same cycle as a flag clear, and the bench checks that the flag survives that cycle. It also checks that a stop then start clears the count, while a plain compare rewrite leaves the count running. A narrow instance is run through its full range to confirm the wrap to zero.

// File: rtl/lp_tmr_pkg.sv
// Package: register addresses, control bit positions and the compare floor
// shared by the timer modules. Assumes a write port of at least 15 data bits.
package lp_tmr_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int BIT_RUN      = 0;
    localparam int BIT_IRQ_EN   = 1;
    localparam int BIT_WAKE_EN  = 2;
    localparam int BIT_PERIODIC = 3;
    localparam int PRE_LSB      = 8;

    localparam int BIT_CLR_IRQ  = 0;
    localparam int BIT_CLR_WAKE = 1;

    localparam int MIN_CMP = 2;
endpackage

// File: rtl/lp_tmr_cfg_delay.sv
// Staging register that holds a written value and makes it active on the
// LAT-th tick after the write. A newer write replaces the staged value and
// restarts the wait. Assumes tick is a single-cycle pulse in the clk domain.
module lp_tmr_cfg_delay #(
    parameter int            W       = 8,
    parameter int            LAT     = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] staged_o,
    output logic [W-1:0] active_o,
    output logic         applied_o
);
    localparam int LW = $clog2(LAT + 1);

    logic [LW-1:0] left;

    // Capture writes, count ticks down and promote the staged value at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_o <= RST_VAL;
            active_o <= RST_VAL;
            left     <= '0;
        end else if (load) begin
            staged_o <= load_val;
            left     <= LW'(LAT);
        end else if (tick && left != '0) begin
            left <= left - LW'(1);
            if (left == LW'(1)) begin
                active_o <= staged_o;
            end
        end
    end

    assign applied_o = tick && !load && (left == LW'(1));
endmodule

// File: rtl/lp_tmr_prescaler.sv
// Tick divider: emits one advance pulse per (div+1) enabled ticks. Clearing
// restarts the phase. Assumes div may change at any time; a phase already
// past a lowered div ends the current period at once.
module lp_tmr_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] div,
    output logic             adv_o
);
    logic [PRE_W-1:0] phase;

    // Step the phase on each enabled tick and wrap at the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (en) begin
            phase <= (phase >= div) ? '0 : phase + PRE_W'(1);
        end
    end

    assign adv_o = en && !clr && (phase >= div);
endmodule

// File: rtl/lp_tmr_counter.sv
// Up-counter with compare. A match is the advance whose next value equals
// the compare value (floored at MIN_CMP). Continuous mode keeps counting;
// periodic mode loads zero on a match. Clear has priority over advance.
module lp_tmr_counter #(
    parameter int CNT_W   = 24,
    parameter int MIN_CMP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             periodic,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CMP);

    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W-1:0] nxt;
    logic             hit;

    // Apply the compare floor and form the next count and the hit test.
    always_comb begin
        cmp_eff = (cmp < FLOOR) ? FLOOR : cmp;
        nxt     = count_o + CNT_W'(1);
        hit     = (nxt == cmp_eff);
    end

    assign match_o = adv && !clr && hit;

    // Hold, clear, advance or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr) begin
            count_o <= '0;
        end else if (adv) begin
            count_o <= (periodic && hit) ? '0 : nxt;
        end
    end
endmodule

// File: rtl/lp_cmp_timer.sv
// Top of the low-power compare timer. Decodes writes, stages control and
// compare through tick-counted delays, runs prescaler and counter, and keeps
// the write-1-to-clear interrupt and wakeup flags. Assumes tick is already
// synchronous to clk and at most one cycle wide.
module lp_cmp_timer
    import lp_tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 7,
    parameter int LAT    = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic              irq_flag_o,
    output logic              wake_flag_o
);
    localparam int CTL_W = PRE_W + 4;

    logic [CTL_W-1:0] ctl_in, ctl_staged, ctl_act;
    logic [CNT_W-1:0] cmp_staged, cmp_act;
    logic             ctl_load, cmp_load, ctrl_applied, cmp_applied;
    logic             run_act, irq_en_act, wake_en_act, periodic_act;
    logic             start, adv, match, clr_irq, clr_wake;
    logic             unused_wr;

    assign ctl_in   = {wr_data[PRE_LSB +: PRE_W], wr_data[BIT_PERIODIC],
                       wr_data[BIT_WAKE_EN], wr_data[BIT_IRQ_EN], wr_data[BIT_RUN]};
    assign ctl_load = wr_en && (wr_addr == ADDR_CTRL);
    assign cmp_load = wr_en && (wr_addr == ADDR_CMP);
    assign clr_irq  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[BIT_CLR_IRQ];
    assign clr_wake = wr_en && (wr_addr == ADDR_FLAG) && wr_data[BIT_CLR_WAKE];
    assign unused_wr = ^{wr_data, cmp_applied};

    lp_tmr_cfg_delay #(.W(CTL_W), .LAT(LAT), .RST_VAL('0)) u_ctl_dly (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(ctl_load), .load_val(ctl_in),
        .staged_o(ctl_staged), .active_o(ctl_act), .applied_o(ctrl_applied)
    );

    lp_tmr_cfg_delay #(.W(CNT_W), .LAT(LAT), .RST_VAL('1)) u_cmp_dly (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cmp_load),
        .load_val(wr_data[CNT_W-1:0]),
        .staged_o(cmp_staged), .active_o(cmp_act), .applied_o(cmp_applied)
    );

    assign run_act      = ctl_act[0];
    assign irq_en_act   = ctl_act[1];
    assign wake_en_act  = ctl_act[2];
    assign periodic_act = ctl_act[3];
    assign start        = ctrl_applied && ctl_staged[0] && !run_act;

    lp_tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(start), .en(tick && run_act),
        .div(ctl_act[CTL_W-1:4]), .adv_o(adv)
    );

    lp_tmr_counter #(.CNT_W(CNT_W), .MIN_CMP(MIN_CMP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv), .periodic(periodic_act),
        .cmp(cmp_act), .count_o(count_o), .match_o(match)
    );

    // Interrupt flag: set on match, cleared by write-1, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_o <= 1'b0;
        end else if (match) begin
            irq_flag_o <= 1'b1;
        end else if (clr_irq) begin
            irq_flag_o <= 1'b0;
        end
    end

    // Wakeup flag: set on match when enabled, cleared by write-1, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_flag_o <= 1'b0;
        end else if (match && wake_en_act) begin
            wake_flag_o <= 1'b1;
        end else if (clr_wake) begin
            wake_flag_o <= 1'b0;
        end
    end

    assign irq_o = irq_flag_o && irq_en_act;
endmodule

// File: rtl/lp_cmp_timer_chk.sv
// Checker for lp_cmp_timer: temporal properties on count and flags, bound
// into every instance of the top module.
module lp_cmp_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_flag_o,
    input logic             wake_flag_o,
    input logic             match,
    input logic             run_act,
    input logic             wake_en_act,
    input logic             periodic_act,
    input logic             clr_irq
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run_act) |=> (count_o == $past(count_o) ||
                               count_o == $past(count_o) + CNT_W'(1) || count_o == '0)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_act |=> ($stable(count_o) || count_o == '0)); // R8
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag_o); // R9
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_en_act && !wake_flag_o) |=> !wake_flag_o); // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq && !match) |=> !irq_flag_o); // R10
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq && match) |=> irq_flag_o); // R11
    AST_CONT_RUNON: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !periodic_act) |=> count_o != '0); // R4
    AST_PERIOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (match && periodic_act) |=> count_o == '0); // R5
    AST_CMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> count_o != CNT_W'(1)); // R6
endmodule

bind lp_cmp_timer lp_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_o(count_o),
    .irq_flag_o(irq_flag_o), .wake_flag_o(wake_flag_o), .match(match),
    .run_act(run_act), .wake_en_act(wake_en_act), .periodic_act(periodic_act),
    .clr_irq(clr_irq)
);

// File: tb/lp_cmp_timer_bench.sv
module lp_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] count;
    logic        irq, irq_flag, wake_flag;
    logic [7:0]  count_n;
    logic        irq_n, irq_flag_n, wake_flag_n;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    lp_cmp_timer u_lp_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count), .irq_o(irq), .irq_flag_o(irq_flag),
        .wake_flag_o(wake_flag)
    );

    lp_cmp_timer #(.CNT_W(8)) u_narrow (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_n), .irq_o(irq_n), .irq_flag_o(irq_flag_n),
        .wake_flag_o(wake_flag_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input bit run, input bit irqe, input bit wake,
                                        input bit per, input int pre);
        logic [31:0] v = '0;
        v[0] = run; v[1] = irqe; v[2] = wake; v[3] = per;
        v[14:8] = 7'(pre);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic start(input logic [31:0] c);
        wr(2'd0, c);
        ticks(3);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count, 0);
        check("R1 irq flag", irq_flag, 0);
        check("R1 wake flag", wake_flag, 0);
        check("R1 irq", irq, 0);
        ticks(10);
        check("R1 stopped", count, 0);
        start(ctl(1, 1, 1, 0, 0));
        ticks(20);
        check("R1 prescale 0", count, 20);
        check("R1 compare max", irq_flag, 0);
    endtask

    task automatic t_latency();
        do_reset();
        wr(2'd0, ctl(1, 0, 0, 0, 0));
        ticks(2);
        check("R2 before 3rd tick", count, 0);
        ticks(1);
        check("R2 on 3rd tick", count, 0);
        ticks(4);
        check("R2 after apply", count, 4);
    endtask

    task automatic t_prescale();
        do_reset();
        start(ctl(1, 0, 0, 0, 3));
        ticks(8);
        check("R3 div4 8 ticks", count, 2);
        ticks(3);
        check("R3 div4 11 ticks", count, 2);
        ticks(1);
        check("R3 div4 12 ticks", count, 3);
    endtask

    task automatic t_continuous();
        do_reset();
        wr(2'd1, 32'd5);
        ticks(3);
        start(ctl(1, 1, 0, 0, 0));
        ticks(4);
        check("R4 before match", count, 4);
        check("R9 no flag yet", irq_flag, 0);
        ticks(1);
        check("R4 at match", count, 5);
        check("R9 irq flag", irq_flag, 1);
        check("R12 irq out", irq, 1);
        check("R9 wake disabled", wake_flag, 0);
        ticks(2);
        check("R4 runs on", count, 7);
    endtask

    task automatic t_periodic();
        do_reset();
        wr(2'd1, 32'd4);
        ticks(3);
        start(ctl(1, 0, 0, 1, 0));
        ticks(3);
        check("R5 before match", count, 3);
        ticks(1);
        check("R5 restart", count, 0);
        check("R5 flag", irq_flag, 1);
        ticks(2);
        check("R5 next period", count, 2);
    endtask

    task automatic t_min_cmp();
        do_reset();
        wr(2'd1, 32'd0);
        ticks(3);
        start(ctl(1, 0, 0, 0, 0));
        ticks(1);
        check("R6 count 1", count, 1);
        check("R6 no match at 1", irq_flag, 0);
        ticks(1);
        check("R6 match at 2", irq_flag, 1);
    endtask

    task automatic t_cmp_running();
        do_reset();
        start(ctl(1, 0, 0, 0, 0));
        ticks(10);
        check("R7 before", count, 10);
        wr(2'd1, 32'd20);
        ticks(3);
        check("R7 count kept", count, 13);
        check("R7 no flag", irq_flag, 0);
        ticks(7);
        check("R7 new compare", irq_flag, 1);
    endtask

    task automatic t_stop_start();
        do_reset();
        start(ctl(1, 0, 0, 0, 0));
        ticks(6);
        check("R8 running", count, 6);
        wr(2'd0, ctl(0, 0, 0, 0, 0));
        ticks(3);
        check("R8 stop lands", count, 9);
        ticks(5);
        check("R8 held", count, 9);
        wr(2'd0, ctl(1, 0, 0, 0, 0));
        ticks(2);
        check("R8 start pending", count, 9);
        ticks(1);
        check("R8 cleared", count, 0);
        ticks(2);
        check("R8 counting", count, 2);
    endtask

    task automatic t_flags();
        do_reset();
        wr(2'd1, 32'd3);
        ticks(3);
        start(ctl(1, 0, 1, 0, 0));
        ticks(3);
        check("R9 irq flag", irq_flag, 1);
        check("R9 wake flag", wake_flag, 1);
        check("R12 masked", irq, 0);
        wr(2'd2, 32'd1);
        check("R10 irq cleared", irq_flag, 0);
        check("R10 wake kept", wake_flag, 1);
        wr(2'd2, 32'd2);
        check("R10 wake cleared", wake_flag, 0);
        ticks(2);
        check("R12 counter runs", count, 5);
    endtask

    task automatic t_collision();
        do_reset();
        wr(2'd1, 32'd4);
        ticks(3);
        start(ctl(1, 1, 0, 0, 0));
        ticks(3);
        check("R11 pre", count, 3);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd1;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        check("R11 match wins", irq_flag, 1);
        check("R11 count", count, 4);
        wr(2'd2, 32'd1);
        check("R10 later clear", irq_flag, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        start(ctl(1, 0, 0, 0, 0));
        ticks(255);
        check("R13 at max", count_n, 255);
        ticks(1);
        check("R13 wrapped", count_n, 0);
        check("R3 wide count", count, 256);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_prescale();
        t_continuous();
        t_periodic();
        t_min_cmp();
        t_cmp_running();
        t_stop_start();
        t_flags();
        t_collision();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule